// File: doc/BRIEF.md
# Address/Data Pair Serial Port

This block is the host-facing serial port of a converter front end. It generates its own serial clock from the master clock and moves 16-bit words MSB first in both directions at once. Every word travels as part of a pair. An address word names the source or the destination, and a data word follows it. Each of the two words is announced by its own one-cycle frame sync.

On the outbound side, two internal producers raise a one-cycle ready strobe with a 16-bit result: the ADC path and the resampling interpolator. The port latches each result and sends it as a pair tagged with that producer's address. When both are pending, ADC data goes first. A transfer already under way always runs to its end, and no pair is sent until the digital power-up input is 1. On the inbound side, the host starts a pair by raising the input frame sync. The port samples the sync and the data on falling serial-clock edges and then issues a single write strobe carrying the address and the data. A pair aimed at the DAC address also updates a held DAC register, which keeps its value until the host writes it again. When chip select is low, the outputs are released, the inputs are ignored, and any word in flight is dropped.

Top module: `pair_serial_port`

## Requirements
- R1: While reset is low, outEn, sclk, sdo, sdofs and wrStrobe are 0 and dacWord is 0.
- R2: An outbound pair is sdofs high for exactly one sclk cycle, then 16 address bits on sdo MSB first, then sdofs high for one sclk cycle, then 16 data bits MSB first. sdo changes after a rising sclk edge, and sdofs is low during every bit cycle. ADC pairs carry address ADC_ADDR (default 0x0001) and interpolator pairs carry INTERP_ADDR (default 0x0002).
- R3: When both results are pending at the start of a pair, the ADC pair is sent first and the interpolator pair follows with no idle cycle.
- R4: A result that becomes ready during a transfer does not interrupt it. It is sent as the next pair, whose sync occupies the sclk cycle straight after the previous data LSB.
- R5: While pwrOn is 0 no sync is sent. Results that arrive in that time stay pending and are sent once pwrOn becomes 1.
- R6: An inbound word starts in the sclk cycle after the one in which sdifs is sampled high. sdifs and sdi are sampled on falling sclk edges. The first word is the address and the second is the data. After the data LSB, wrStrobe pulses for one clk with wrAddr and wrData.
- R7: If sdifs is high in the LSB cycle of the address word, the data word starts in the very next sclk cycle.
- R8: If sdifs goes high for one cycle in the middle of a word (not in its LSB cycle), it has no effect on the word or the pair.
- R9: With cs low, outEn, sclk, sdo and sdofs are 0, sdi and sdifs cause no write, and a word that was being sent or received is lost, together with the rest of its pair.
- R10: A write to DAC_ADDR (default 0x0006) loads dacWord. Writes to other addresses leave it unchanged, and it holds its value indefinitely.
- R11: sclk has a period of DIV clk cycles with DIV/2 cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| pwrOn | input | 1 | Digital power-up gate; 1 allows outbound pairs |
| adcReady | input | 1 | One-cycle strobe: ADC result valid |
| adcData | input | 16 | ADC result |
| interpReady | input | 1 | One-cycle strobe: interpolator result valid |
| interpData | input | 16 | Interpolator result |
| sdi | input | 1 | Serial data from host |
| sdifs | input | 1 | Input frame sync from host |
| sclk | output | 1 | Serial clock (0 when released) |
| sdo | output | 1 | Serial data to host |
| sdofs | output | 1 | Output frame sync |
| outEn | output | 1 | Drive enable for sclk, sdo, sdofs; 0 means high impedance |
| wrStrobe | output | 1 | One-cycle pulse per received pair |
| wrAddr | output | 16 | Address word of the received pair |
| wrData | output | 16 | Data word of the received pair |
| dacWord | output | 16 | Held DAC input register |

## Verification
The assertions assume that DIV is even and at least 2 and that ready strobes last one clk. They also assume the host changes sdi and sdifs only between sclk edges and holds sdifs high for whole sclk cycles. The write-pulse check further relies on two received words never ending less than one sclk apart, which the 16-bit word length guarantees. The stimulus stays inside these limits. Every host-side drive happens a nanosecond after an observed rising sclk edge, every ready strobe is driven on a falling clk edge for one cycle, and chip select is changed only while the serial clock is known to be in a settled phase.

// File: rtl/psp_pkg.sv
`timescale 1ns/1ps
package psp_pkg;

  typedef enum logic [2:0] {
    TX_IDLE   = 3'd0,
    TX_SYNC_A = 3'd1,
    TX_ADDR   = 3'd2,
    TX_SYNC_D = 3'd3,
    TX_DATA   = 3'd4
  } txState_e;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic startAdc;      // latch ADC pair into shifter
    logic startInterp;   // latch interpolator pair into shifter
    logic loadData;      // move data word into shifter
    logic txShift;       // advance outbound shifter one bit
    logic rxShift;       // capture one inbound bit
    logic rxWordDone;    // inbound word complete this cycle
    logic rxWordIsData;  // completed word is the data half of a pair
  } portStrobes_t;

endpackage

// File: rtl/psp_ctrl.sv
`timescale 1ns/1ps
module psp_ctrl
  import psp_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int WORD_W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cs,
  input  logic         pwrOn,
  input  logic         adcReady,
  input  logic         interpReady,
  input  logic         sdifs,
  output logic         sclkInt,
  output logic         sdofsInt,
  output logic         bitPhase,
  output portStrobes_t strobes
);

  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  // serial clock as rise/fall events in the master clock domain
  logic [CNT_W-1:0] divCnt;
  logic riseEv, fallEv;

  assign riseEv = (divCnt == CNT_W'(DIV - 1));
  assign fallEv = (divCnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkInt <= 1'b0;
    end else begin
      divCnt <= riseEv ? '0 : divCnt + 1'b1;
      if (riseEv)      sclkInt <= 1'b1;
      else if (fallEv) sclkInt <= 1'b0;
    end
  end

  // outbound pending flags and arbitration
  txState_e       txState;
  logic [BIT_W-1:0] txBit;
  logic adcPend, interpPend;
  logic slotFree, startAdc, startInterp, startAny;

  assign slotFree    = (txState == TX_IDLE) ||
                       (txState == TX_DATA && txBit == LAST_BIT);
  assign startAny    = riseEv && cs && pwrOn && slotFree && (adcPend || interpPend);
  assign startAdc    = startAny && adcPend;
  assign startInterp = startAny && !adcPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcPend    <= 1'b0;
      interpPend <= 1'b0;
    end else begin
      if (adcReady)         adcPend <= 1'b1;
      else if (startAdc)    adcPend <= 1'b0;
      if (interpReady)      interpPend <= 1'b1;
      else if (startInterp) interpPend <= 1'b0;
    end
  end

  // outbound sequencing, advanced on rising serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txBit   <= '0;
    end else if (!cs) begin
      txState <= TX_IDLE;
      txBit   <= '0;
    end else if (riseEv) begin
      unique case (txState)
        TX_IDLE:   if (startAny) txState <= TX_SYNC_A;
        TX_SYNC_A: begin txState <= TX_ADDR; txBit <= '0; end
        TX_ADDR:   if (txBit == LAST_BIT) txState <= TX_SYNC_D;
                   else txBit <= txBit + 1'b1;
        TX_SYNC_D: begin txState <= TX_DATA; txBit <= '0; end
        TX_DATA:   if (txBit == LAST_BIT) txState <= startAny ? TX_SYNC_A : TX_IDLE;
                   else txBit <= txBit + 1'b1;
        default:   txState <= TX_IDLE;
      endcase
    end
  end

  assign sdofsInt = (txState == TX_SYNC_A) || (txState == TX_SYNC_D);
  assign bitPhase = (txState == TX_ADDR) || (txState == TX_DATA);

  // inbound sequencing, advanced on falling serial clock
  logic             rxActive;
  logic             rxIsData;
  logic [BIT_W-1:0] rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxIsData <= 1'b0;
      rxBit    <= '0;
    end else if (!cs) begin
      rxActive <= 1'b0;
      rxIsData <= 1'b0;
      rxBit    <= '0;
    end else if (fallEv) begin
      if (!rxActive) begin
        if (sdifs) begin
          rxActive <= 1'b1;
          rxBit    <= '0;
        end
      end else if (rxBit == LAST_BIT) begin
        rxActive <= sdifs;           // sync honoured only in the LSB cycle
        rxBit    <= '0;
        rxIsData <= !rxIsData;
      end else begin
        rxBit <= rxBit + 1'b1;
      end
    end
  end

  always_comb begin
    strobes              = '0;
    strobes.startAdc     = startAdc;
    strobes.startInterp  = startInterp;
    strobes.loadData     = riseEv && cs && txState == TX_ADDR && txBit == LAST_BIT;
    strobes.txShift      = riseEv && cs && bitPhase && txBit != LAST_BIT;
    strobes.rxShift      = fallEv && cs && rxActive;
    strobes.rxWordDone   = fallEv && cs && rxActive && rxBit == LAST_BIT;
    strobes.rxWordIsData = rxIsData;
  end

  AST_SCLK_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!riseEv && !fallEv) |=> $stable(sclkInt)) else $error("sclk moved off its events"); // R11

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (riseEv && sdofsInt) |=> !sdofsInt) else $error("sync lasted past one sclk"); // R2

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrOn && txState == TX_IDLE) |=> txState == TX_IDLE) else $error("pair began while powered down"); // R5

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> (txState == TX_IDLE && !rxActive)) else $error("transfer survived chip deselect"); // R9

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startAdc, startInterp})) else $error("two sources started together"); // R3

endmodule

// File: rtl/psp_datapath.sv
`timescale 1ns/1ps
module psp_datapath
  import psp_pkg::*;
#(
  parameter int                WORD_W      = 16,
  parameter logic [WORD_W-1:0] ADC_ADDR    = 16'h0001,
  parameter logic [WORD_W-1:0] INTERP_ADDR = 16'h0002,
  parameter logic [WORD_W-1:0] DAC_ADDR    = 16'h0006
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic              adcReady,
  input  logic [WORD_W-1:0] adcData,
  input  logic              interpReady,
  input  logic [WORD_W-1:0] interpData,
  input  logic              sdi,
  input  logic              bitPhase,
  output logic              sdoInt,
  output logic              wrStrobe,
  output logic [WORD_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] dacWord
);

  // result holding registers and outbound shifter
  logic [WORD_W-1:0] adcHold, interpHold, txNext, txSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcHold    <= '0;
      interpHold <= '0;
      txNext     <= '0;
      txSh       <= '0;
    end else begin
      if (adcReady)    adcHold    <= adcData;
      if (interpReady) interpHold <= interpData;
      if (strobes.startAdc) begin
        txSh   <= ADC_ADDR;
        txNext <= adcHold;
      end else if (strobes.startInterp) begin
        txSh   <= INTERP_ADDR;
        txNext <= interpHold;
      end else if (strobes.loadData) begin
        txSh <= txNext;
      end else if (strobes.txShift) begin
        txSh <= {txSh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sdoInt = bitPhase & txSh[WORD_W-1];

  // inbound shifter, address latch, write port and DAC register
  logic [WORD_W-1:0] rxSh, addrLatch, wordIn;

  assign wordIn = {rxSh[WORD_W-2:0], sdi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      addrLatch <= '0;
      wrStrobe  <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      dacWord   <= '0;
    end else begin
      wrStrobe <= 1'b0;
      if (strobes.rxShift) rxSh <= wordIn;
      if (strobes.rxWordDone) begin
        if (!strobes.rxWordIsData) begin
          addrLatch <= wordIn;
        end else begin
          wrStrobe <= 1'b1;
          wrAddr   <= addrLatch;
          wrData   <= wordIn;
          if (addrLatch == DAC_ADDR) dacWord <= wordIn;
        end
      end
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe) else $error("write strobe wider than one cycle"); // R6

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.rxWordDone) |-> $stable(dacWord)) else $error("DAC register moved without a word"); // R10

endmodule

// File: rtl/pair_serial_port.sv
`timescale 1ns/1ps
module pair_serial_port
  import psp_pkg::*;
#(
  parameter int                DIV         = 8,
  parameter int                WORD_W      = 16,
  parameter logic [WORD_W-1:0] ADC_ADDR    = 16'h0001,
  parameter logic [WORD_W-1:0] INTERP_ADDR = 16'h0002,
  parameter logic [WORD_W-1:0] DAC_ADDR    = 16'h0006
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              pwrOn,
  input  logic              adcReady,
  input  logic [WORD_W-1:0] adcData,
  input  logic              interpReady,
  input  logic [WORD_W-1:0] interpData,
  input  logic              sdi,
  input  logic              sdifs,
  output logic              sclk,
  output logic              sdo,
  output logic              sdofs,
  output logic              outEn,
  output logic              wrStrobe,
  output logic [WORD_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] dacWord
);

  portStrobes_t strobes;
  logic sclkInt, sdofsInt, sdoInt, bitPhase;

  psp_ctrl #(.DIV(DIV), .WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cs(cs), .pwrOn(pwrOn),
    .adcReady(adcReady), .interpReady(interpReady), .sdifs(sdifs),
    .sclkInt(sclkInt), .sdofsInt(sdofsInt), .bitPhase(bitPhase),
    .strobes(strobes)
  );

  psp_datapath #(
    .WORD_W(WORD_W), .ADC_ADDR(ADC_ADDR),
    .INTERP_ADDR(INTERP_ADDR), .DAC_ADDR(DAC_ADDR)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .adcReady(adcReady), .adcData(adcData),
    .interpReady(interpReady), .interpData(interpData),
    .sdi(sdi), .bitPhase(bitPhase), .sdoInt(sdoInt),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .dacWord(dacWord)
  );

  assign outEn = cs & rstN;
  assign sclk  = outEn & sclkInt;
  assign sdo   = outEn & sdoInt;
  assign sdofs = outEn & sdofsInt;

  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cs |-> (!sclk && !sdo && !sdofs)) else $error("pins driven while deselected"); // R9

endmodule

// File: tb/tb_pair_serial_port.sv
`timescale 1ns/1ps
module tb_pair_serial_port;

  localparam int DIV = 4;
  localparam logic [15:0] A_ADC = 16'h0001, A_INT = 16'h0002, A_DAC = 16'h0006;

  logic clk = 0, rstN = 0, cs = 0, pwrOn = 0;
  logic adcReady = 0, interpReady = 0, sdi = 0, sdifs = 0;
  logic [15:0] adcData = 0, interpData = 0;
  logic sclk, sdo, sdofs, outEn, wrStrobe;
  logic [15:0] wrAddr, wrData, dacWord;

  pair_serial_port #(.DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .cs(cs), .pwrOn(pwrOn),
    .adcReady(adcReady), .adcData(adcData),
    .interpReady(interpReady), .interpData(interpData),
    .sdi(sdi), .sdifs(sdifs), .sclk(sclk), .sdo(sdo), .sdofs(sdofs),
    .outEn(outEn), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .dacWord(dacWord)
  );

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0, wrCount = 0, sofsHi = 0;

  always @(negedge clk) begin
    if (wrStrobe) wrCount++;
    if (sdofs) sofsHi++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseAdc(input logic [15:0] v);
    @(negedge clk); adcData = v; adcReady = 1;
    @(negedge clk); adcReady = 0;
  endtask

  task automatic pulseInt(input logic [15:0] v);
    @(negedge clk); interpData = v; interpReady = 1;
    @(negedge clk); interpReady = 0;
  endtask

  // collect one outbound pair; the sync must appear within maxWait falling edges
  task automatic captureTx(input int maxWait, output logic [15:0] a,
                           output logic [15:0] d, output bit ok);
    int w;
    a = 0; d = 0; ok = 1; w = 1;
    @(negedge sclk);
    while (!sdofs) begin
      if (w >= maxWait) begin ok = 0; return; end
      @(negedge sclk); w++;
    end
    for (int i = 15; i >= 0; i--) begin
      @(negedge sclk); if (sdofs) ok = 0; a[i] = sdo;
    end
    @(negedge sclk); if (!sdofs) ok = 0;
    for (int i = 15; i >= 0; i--) begin
      @(negedge sclk); if (sdofs) ok = 0; d[i] = sdo;
    end
  endtask

  // host sends a pair; gap 0 = early sync in the address LSB cycle
  task automatic hostSend(input logic [15:0] a, input logic [15:0] d,
                          input int gap, input int glitchBit);
    @(posedge sclk); #1 sdifs = 1;
    for (int i = 15; i >= 0; i--) begin
      @(posedge sclk); #1 sdi = a[i];
      sdifs = (i == 0 && gap == 0) || (i == glitchBit);
    end
    for (int g = 0; g < gap; g++) begin
      @(posedge sclk); #1 sdi = 0; sdifs = (g == gap - 1);
    end
    for (int i = 15; i >= 0; i--) begin
      @(posedge sclk); #1 sdi = d[i]; sdifs = 0;
    end
    @(posedge sclk); #1 sdi = 0; sdifs = 0;
    @(posedge sclk);
  endtask

  initial begin
    #1_000_000;
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [15:0] a1, d1, a2, d2;
    bit ok1, ok2;
    int t0, t1, t2, wc;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 outEn", outEn, 0);
    chk("R1 sdofs/sdo/sclk", {sdofs, sdo, sclk}, 0);
    chk("R1 wrStrobe", wrStrobe, 0);
    chk("R1 dacWord", dacWord, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk("R9 outEn with cs low", outEn, 0);
    cs = 1;
    @(negedge clk);
    chk("R9 outEn with cs high", outEn, 1);

    // R11 serial clock shape
    @(posedge sclk); t0 = $time;
    @(negedge sclk); t1 = $time;
    @(posedge sclk); t2 = $time;
    chk("R11 period", t2 - t0, DIV * 10);
    chk("R11 high time", t1 - t0, DIV * 5);

    // R5 held while powered down, sent after power-up
    pulseAdc(16'hC3A5);
    sofsHi = 0;
    repeat (50) @(posedge sclk);
    chk("R5 no sync while off", sofsHi, 0);
    @(negedge clk); pwrOn = 1;
    captureTx(10, a1, d1, ok1);
    chk("R5 framing", ok1, 1);
    chk("R5 addr", a1, A_ADC);
    chk("R5 data", d1, 16'hC3A5);

    // R2 sweep of interpolator pairs, walking one and its complement
    for (int k = 0; k < 16; k++) begin
      pulseInt((16'h1 << k) ^ ((k % 2) ? 16'hFFFF : 16'h0000));
      captureTx(10, a1, d1, ok1);
      chk("R2 framing", ok1, 1);
      chk("R2 addr", a1, A_INT);
      chk("R2 data", d1, (16'h1 << k) ^ ((k % 2) ? 16'hFFFF : 16'h0000));
    end

    // R3 both pending: ADC first, interpolator straight after
    @(negedge clk); pwrOn = 0;
    pulseInt(16'h1357);
    pulseAdc(16'h2468);
    @(negedge clk); pwrOn = 1;
    captureTx(10, a1, d1, ok1);
    captureTx(1, a2, d2, ok2);
    chk("R3 first addr", a1, A_ADC);
    chk("R3 first data", d1, 16'h2468);
    chk("R3 second back-to-back", ok2, 1);
    chk("R3 second addr", a2, A_INT);
    chk("R3 second data", d2, 16'h1357);

    // R4 ADC result arriving mid-transfer waits for the current pair
    pulseInt(16'h0F0F);
    fork
      begin
        captureTx(10, a1, d1, ok1);
        captureTx(1, a2, d2, ok2);
      end
      begin
        wait (sdofs == 1);
        repeat (6) @(posedge sclk);
        pulseAdc(16'hBEEF);
      end
    join
    chk("R4 current pair intact", {ok1, a1, d1}, {1'b1, A_INT, 16'h0F0F});
    chk("R4 next pair immediate", ok2, 1);
    chk("R4 next pair content", {a2, d2}, {A_ADC, 16'hBEEF});

    @(negedge clk); pwrOn = 0;

    // R6 basic inbound pair to a non-DAC address; R10 DAC untouched
    wc = wrCount;
    hostSend(16'h0010, 16'h1234, 3, -1);
    chk("R6 one write", wrCount - wc, 1);
    chk("R6 wrAddr", wrAddr, 16'h0010);
    chk("R6 wrData", wrData, 16'h1234);
    chk("R10 other address leaves DAC", dacWord, 0);

    // R6/R7/R10 sweep at the DAC address with gaps 0..3
    for (int k = 0; k < 16; k++) begin
      wc = wrCount;
      hostSend(A_DAC, (16'h1 << k) ^ 16'hF00F, k % 4, -1);
      chk((k % 4 == 0) ? "R7 early sync write" : "R6 write", wrCount - wc, 1);
      chk("R6 wrData sweep", wrData, (16'h1 << k) ^ 16'hF00F);
      chk("R10 dacWord sweep", dacWord, (16'h1 << k) ^ 16'hF00F);
    end

    // R8 sync glitch inside the address word is ignored
    wc = wrCount;
    hostSend(16'h00A0, 16'h7E81, 1, 7);
    chk("R8 one write", wrCount - wc, 1);
    chk("R8 addr intact", wrAddr, 16'h00A0);
    chk("R8 data intact", wrData, 16'h7E81);

    // R10 hold: later write elsewhere and idle time keep dacWord
    repeat (40) @(posedge sclk);
    chk("R10 holds after idle", dacWord, (16'h1 << 15) ^ 16'hF00F);

    // R9 outbound pair lost on deselect
    @(negedge clk); pwrOn = 1;
    pulseAdc(16'h4242);
    wait (sdofs == 1);
    repeat (4) @(posedge sclk);
    #1 cs = 0;
    repeat (2) @(negedge clk);
    chk("R9 released pins", {outEn, sclk, sdo, sdofs}, 0);
    // R9 inputs ignored while deselected
    wc = wrCount;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sdifs = i[2]; sdi = i[0];
    end
    @(negedge clk); sdifs = 0; sdi = 0;
    chk("R9 no write while deselected", wrCount - wc, 0);
    @(negedge clk); cs = 1;
    sofsHi = 0;
    repeat (50) @(posedge sclk);
    chk("R9 aborted pair not resent", sofsHi, 0);
    @(negedge clk); pwrOn = 0;

    // R9 partial inbound word lost on deselect
    @(posedge sclk); #1 sdifs = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk); #1 sdifs = 0; sdi = 1;
    end
    #1 cs = 0;
    repeat (3 * DIV) @(negedge clk);
    sdi = 0;
    @(negedge clk); cs = 1;
    wc = wrCount;
    hostSend(A_DAC, 16'h5A5A, 1, -1);
    chk("R9 only the new pair written", wrCount - wc, 1);
    chk("R9 addr after abort", wrAddr, A_DAC);
    chk("R10 dac after abort", dacWord, 16'h5A5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule